// File: doc/BRIEF.md
# Pipelined Burst Synchronous Static Memory Front End

This block is the control and storage core of a synchronous static memory with registered inputs and a read path that is pipelined by one stage. Each rising clock edge it samples two active-low address strobes (one meant for a processor, one for a memory controller), three chip enables, an advance input, a global write, a write enable and one strobe per byte lane. From these it picks one action: deselect, start a read, start a write, step the burst address, or hold the burst address.

Reads and byte-masked writes go to a small array that is 32 bits wide and set by a parameter. The low address bits count through a four-beat burst. The count order is selected by an input: either wrapping increment or XOR with the start offset. Read data passes through an output register. An asynchronous output enable then gates it onto a split data-out port. A valid flag marks the cycles in which the bus would be driven.

Top module: `burst_sram_fe`

## Requirements
- R1: After reset the block is deselected, `rvalid_o` is 0 and `rdata_o` is zero, and it stays so while no strobe is asserted.
- R2: The chip counts as enabled only when `ce_pri_n`=0, `ce_hi`=1 and `ce_lo_n`=0. An effective strobe with any other enable combination deselects: nothing is written, and `rvalid_o` is 0 two edges later.
- R3: `proc_stb_n`=0 while `ce_pri_n`=1 is ignored. With `ctrl_stb_n`=1 the running burst continues as if no strobe were present.
- R4: `ctrl_stb_n`=0 while `ce_pri_n`=1 deselects. This happens even during a burst, and the block stays deselected until a new start.
- R5: A start by `proc_stb_n`=0 (with `ce_pri_n`=0) is always a read, whatever the write inputs are. A write can only start with `ctrl_stb_n`=0 and `proc_stb_n`=1.
- R6: `gwr_n`=0 marks a write of all four byte lanes, whatever `wr_n` and `lane_n` are.
- R7: With `gwr_n`=1 and `wr_n`=0, lane k (bits 8k+7..8k) is written only when `lane_n[k]`=0. With `wr_n`=0 and `lane_n`=4'hF, or with `gwr_n`=`wr_n`=1, the cycle is a read.
- R8: Suppose the address of a read is sampled at edge N. Its data appears on `rdata_o`, with `rvalid_o`=1, after edge N+1 and not before.
- R9: `oe_n`=1 forces `rvalid_o`=0 and `rdata_o`=0 with no clock edge. The edge after a write or deselect command shows no data.
- R10: With `linear_i`=1, each advance adds 1 to the two low address bits, modulo 4. The upper address bits stay those of the start address.
- R11: With `linear_i`=0, the beat address low bits are the start low bits XOR the beat count.
- R12: With no strobe, `adv_n`=0 steps and `adv_n`=1 holds the burst address. The burst keeps its type: in a write burst each such cycle writes the lanes selected by the write inputs at that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | ADDR_W | Word address, sampled on a start |
| proc_stb_n | input | 1 | Processor-side address strobe, active low |
| ctrl_stb_n | input | 1 | Controller-side address strobe, active low |
| ce_pri_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Second chip enable, active high |
| ce_lo_n | input | 1 | Third chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write of all lanes, active low |
| wr_n | input | 1 | Write enable qualified by lane strobes, active low |
| lane_n | input | DATA_W/8 | Per-lane write strobes, active low |
| linear_i | input | 1 | Burst order: 1 wrapping increment, 0 XOR order |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | DATA_W | Write data, sampled with the write command |
| rdata_o | output | DATA_W | Read data, zero when not driven |
| rvalid_o | output | 1 | High when read data is driven |

## Verification
The bench builds the block with its default parameters: a 6-bit word address, a 2-bit burst counter and 32-bit data. With 64 words it can write several four-word groups with known contents. Bursts that start mid-group show both the wrap of the low bits and the kept upper bits. Four lanes let one partial write mix written and kept bytes in a single readable word.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_DESEL = 2'd1,
        CMD_READ  = 2'd2,
        CMD_WRITE = 2'd3
    } bsf_cmd_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bsf_op_e;

endpackage

// File: rtl/bsf_cmd_decode.sv
module bsf_cmd_decode
    import bsf_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              ce_pri_n,
    input  logic              ce_hi,
    input  logic              ce_lo_n,
    input  logic              gwr_n,
    input  logic              wr_n,
    input  logic [NBYTES-1:0] lane_n,
    output bsf_cmd_e          cmd,
    output logic [NBYTES-1:0] lane_we
);

    logic chip_on;
    logic proc_live;

    always_comb begin
        chip_on   = !ce_pri_n && ce_hi && !ce_lo_n;
        // processor strobe only counts while the primary enable is active
        proc_live = !proc_stb_n && !ce_pri_n;

        if (!gwr_n) begin
            lane_we = '1;
        end else if (!wr_n) begin
            lane_we = ~lane_n;
        end else begin
            lane_we = '0;
        end

        if (proc_live) begin
            cmd = chip_on ? CMD_READ : CMD_DESEL;
        end else if (!ctrl_stb_n) begin
            if (!chip_on) begin
                cmd = CMD_DESEL;
            end else if (|lane_we) begin
                cmd = CMD_WRITE;
            end else begin
                cmd = CMD_READ;
            end
        end else begin
            cmd = CMD_HOLD;
        end
    end

endmodule

// File: rtl/bsf_burst_seq.sv
module bsf_burst_seq #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] base,
    input  logic [BURST_W-1:0] cnt,
    input  logic               linear,
    output logic [BURST_W-1:0] lo
);

    always_comb begin
        if (linear) begin
            lo = BURST_W'(base + cnt);
        end else begin
            lo = base ^ cnt;
        end
    end

endmodule

// File: rtl/bsf_array.sv
module bsf_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [NBYTES-1:0]   wr_lanes,
    input  logic [NBYTES*8-1:0] wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [NBYTES*8-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];
        logic [7:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[b]) begin
                lane_mem[wr_addr] <= wr_data[8*b +: 8];
            end
        end

        always_ff @(posedge clk) begin
            if (rd_en) begin
                lane_q <= lane_mem[rd_addr];
            end
        end

        assign rd_data[8*b +: 8] = lane_q;
    end

endmodule

// File: rtl/burst_sram_fe.sv
module burst_sram_fe
    import bsf_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    parameter int BURST_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     proc_stb_n,
    input  logic                     ctrl_stb_n,
    input  logic                     ce_pri_n,
    input  logic                     ce_hi,
    input  logic                     ce_lo_n,
    input  logic                     adv_n,
    input  logic                     gwr_n,
    input  logic                     wr_n,
    input  logic [DATA_W/8-1:0]      lane_n,
    input  logic                     linear_i,
    input  logic                     oe_n,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [DATA_W-1:0]        rdata_o,
    output logic                     rvalid_o
);

    localparam int NBYTES = DATA_W / 8;
    localparam int HI_W   = ADDR_W - BURST_W;

    typedef struct packed {
        bsf_op_e             op;
        logic [HI_W-1:0]     hi;
        logic [BURST_W-1:0]  base;
        logic [BURST_W-1:0]  cnt;
        logic                rd_pend;
        logic [ADDR_W-1:0]   rd_addr;
        logic                vld;
    } bsf_state_t;

    bsf_state_t st_d, st_q;

    bsf_cmd_e            cmd;
    logic [NBYTES-1:0]   lane_we;
    logic [BURST_W-1:0]  cnt_nx;
    logic [BURST_W-1:0]  beat_lo;
    logic [ADDR_W-1:0]   beat_addr;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [DATA_W-1:0]   arr_q;

    bsf_cmd_decode #(.NBYTES(NBYTES)) u_dec (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .ce_pri_n   (ce_pri_n),
        .ce_hi      (ce_hi),
        .ce_lo_n    (ce_lo_n),
        .gwr_n      (gwr_n),
        .wr_n       (wr_n),
        .lane_n     (lane_n),
        .cmd        (cmd),
        .lane_we    (lane_we)
    );

    assign cnt_nx = adv_n ? st_q.cnt : BURST_W'(st_q.cnt + 1'b1);

    bsf_burst_seq #(.BURST_W(BURST_W)) u_seq (
        .base   (st_q.base),
        .cnt    (cnt_nx),
        .linear (linear_i),
        .lo     (beat_lo)
    );

    assign beat_addr = {st_q.hi, beat_lo};

    always_comb begin
        st_d         = st_q;
        st_d.rd_pend = 1'b0;
        st_d.vld     = st_q.rd_pend;
        wr_en        = 1'b0;
        wr_addr      = beat_addr;

        unique case (cmd)
            CMD_DESEL: begin
                st_d.op = OP_IDLE;
            end
            CMD_READ, CMD_WRITE: begin
                st_d.op      = (cmd == CMD_WRITE) ? OP_WRITE : OP_READ;
                st_d.hi      = addr_i[ADDR_W-1:BURST_W];
                st_d.base    = addr_i[BURST_W-1:0];
                st_d.cnt     = '0;
                st_d.rd_pend = (cmd == CMD_READ);
                st_d.rd_addr = addr_i;
                wr_en        = (cmd == CMD_WRITE);
                wr_addr      = addr_i;
            end
            default: begin
                if (st_q.op == OP_READ) begin
                    st_d.cnt     = cnt_nx;
                    st_d.rd_pend = 1'b1;
                    st_d.rd_addr = beat_addr;
                end else if (st_q.op == OP_WRITE) begin
                    st_d.cnt = cnt_nx;
                    wr_en    = |lane_we;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{op: OP_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    bsf_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_arr (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_lanes (lane_we),
        .wr_data  (wdata_i),
        .rd_en    (st_q.rd_pend),
        .rd_addr  (st_q.rd_addr),
        .rd_data  (arr_q)
    );

    assign rvalid_o = st_q.vld && !oe_n;
    assign rdata_o  = rvalid_o ? arr_q : '0;

endmodule

// File: rtl/bsf_checker.sv
module bsf_checker (
    input logic clk,
    input logic rst_n,
    input logic proc_stb_n,
    input logic ctrl_stb_n,
    input logic ce_pri_n,
    input logic ce_hi,
    input logic ce_lo_n,
    input logic gwr_n,
    input logic oe_n,
    input logic rvalid_o
);

    logic chip_on;
    assign chip_on = !ce_pri_n && ce_hi && !ce_lo_n;

    a_r9_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rvalid_o);

    a_r2_disabled_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        (((!proc_stb_n && !ce_pri_n) || !ctrl_stb_n) && !chip_on) |-> ##2 !rvalid_o);

    a_r4_ctrl_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_stb_n && ce_pri_n) |-> ##2 !rvalid_o);

    a_r5_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n && chip_on) |-> ##2 (oe_n || rvalid_o));

    a_r6_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_stb_n && proc_stb_n && chip_on && !gwr_n) |-> ##2 !rvalid_o);

endmodule

bind burst_sram_fe bsf_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .ce_pri_n   (ce_pri_n),
    .ce_hi      (ce_hi),
    .ce_lo_n    (ce_lo_n),
    .gwr_n      (gwr_n),
    .oe_n       (oe_n),
    .rvalid_o   (rvalid_o)
);

// File: tb/burst_sram_fe_tb_top.sv
`timescale 1ns/1ps
module burst_sram_fe_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr_i;
    logic        proc_stb_n, ctrl_stb_n, ce_pri_n, ce_hi, ce_lo_n;
    logic        adv_n, gwr_n, wr_n, linear_i, oe_n;
    logic [3:0]  lane_n;
    logic [31:0] wdata_i;
    logic [31:0] rdata_o;
    logic        rvalid_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] ref_mem [64];

    always #4 clk = ~clk;

    burst_sram_fe dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
        .ce_pri_n(ce_pri_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
        .adv_n(adv_n), .gwr_n(gwr_n), .wr_n(wr_n), .lane_n(lane_n),
        .linear_i(linear_i), .oe_n(oe_n), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        proc_stb_n = 1'b1; ctrl_stb_n = 1'b1;
        ce_pri_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
        adv_n = 1'b1; gwr_n = 1'b1; wr_n = 1'b1; lane_n = 4'hF;
        oe_n = 1'b0; addr_i = '0; wdata_i = '0;
    endtask

    task automatic wr_global(input int a, input logic [31:0] v);
        idle_in();
        ctrl_stb_n = 1'b0; gwr_n = 1'b0; addr_i = 6'(a); wdata_i = v;
        tick();
        ref_mem[a] = v;
        idle_in();
    endtask

    task automatic rd_check(input int a, input string tag);
        idle_in();
        ctrl_stb_n = 1'b0; addr_i = 6'(a);
        tick();
        idle_in();
        tick();
        chk(tag, 32'(rvalid_o), 32'd1);
        chk(tag, rdata_o, ref_mem[a]);
    endtask

    task automatic desel();
        idle_in();
        ctrl_stb_n = 1'b0; ce_pri_n = 1'b1;
        tick();
        idle_in();
        tick();
    endtask

    // R10/R11/R12: burst with a list of advance values, checks each beat
    task automatic burst_read(input int start, input logic lin, input logic [3:0] adv_pat,
                              input string tag);
        int cnt = 0;
        linear_i = lin;
        idle_in();
        ctrl_stb_n = 1'b0; addr_i = 6'(start);
        tick();
        for (int k = 0; k < 4; k++) begin
            int lo;
            int exp_a;
            lo    = lin ? ((start + cnt) % 4) : ((start % 4) ^ cnt);
            exp_a = (start & ~3) | lo;
            idle_in();
            adv_n = adv_pat[k];
            tick();
            chk(tag, rdata_o, ref_mem[exp_a]);
            if (!adv_pat[k]) cnt = (cnt + 1) % 4;
        end
        linear_i = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 rvalid in reset", 32'(rvalid_o), 32'd0);
        chk("R1 rdata in reset", rdata_o, 32'd0);
        rst_n = 1'b1;
        tick(); tick();
        chk("R1 rvalid idle", 32'(rvalid_o), 32'd0);
        chk("R1 rdata idle", rdata_o, 32'd0);
    endtask

    task automatic t_global();
        wr_global(5, 32'h1234_5678);
        idle_in();
        ctrl_stb_n = 1'b0; gwr_n = 1'b0; wr_n = 1'b0; lane_n = 4'b1110;
        addr_i = 6'd6; wdata_i = 32'hCAFE_F00D;
        tick();
        ref_mem[6] = 32'hCAFE_F00D;
        rd_check(5, "R6 global write");
        rd_check(6, "R6 global overrides lanes");
    endtask

    task automatic t_bytes();
        wr_global(7, 32'h1122_3344);
        idle_in();
        ctrl_stb_n = 1'b0; wr_n = 1'b0; lane_n = 4'b1010;
        addr_i = 6'd7; wdata_i = 32'hAABB_CCDD;
        tick();
        ref_mem[7] = 32'h11BB_33DD;
        rd_check(7, "R7 lane mask");
        idle_in();
        ctrl_stb_n = 1'b0; wr_n = 1'b0; lane_n = 4'hF;
        addr_i = 6'd7; wdata_i = 32'hFFFF_FFFF;
        tick();
        idle_in();
        tick();
        chk("R7 no-lane cycle reads", 32'(rvalid_o), 32'd1);
        chk("R7 no-lane cycle data", rdata_o, 32'h11BB_33DD);
    endtask

    task automatic t_latency();
        desel();
        ctrl_stb_n = 1'b0; addr_i = 6'd5;
        tick();
        chk("R8 not before N+1", 32'(rvalid_o), 32'd0);
        idle_in();
        tick();
        chk("R8 valid after N+1", 32'(rvalid_o), 32'd1);
        chk("R8 data after N+1", rdata_o, ref_mem[5]);
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        #1;
        chk("R9 oe high valid", 32'(rvalid_o), 32'd0);
        chk("R9 oe high data", rdata_o, 32'd0);
        oe_n = 1'b0;
        #1;
        chk("R9 oe low valid", 32'(rvalid_o), 32'd1);
        @(negedge clk);
        idle_in();
        ctrl_stb_n = 1'b0; gwr_n = 1'b0; addr_i = 6'd9; wdata_i = 32'h0909_0909;
        tick();
        ref_mem[9] = 32'h0909_0909;
        idle_in();
        tick();
        chk("R9 write not driven", 32'(rvalid_o), 32'd0);
    endtask

    task automatic t_bursts();
        for (int i = 0; i < 4; i++) wr_global(40 + i, 32'hA000_0000 + 32'(i));
        burst_read(42, 1'b1, 4'b1000, "R10 linear wrap");
        burst_read(41, 1'b0, 4'b1000, "R11 xor order");
        burst_read(42, 1'b1, 4'b1011, "R12 suspend read");
    endtask

    task automatic t_wr_burst();
        wr_global(50, 32'h5050_5050);
        idle_in();
        ctrl_stb_n = 1'b0; gwr_n = 1'b0; addr_i = 6'd48; wdata_i = 32'h0000_AAAA;
        tick();
        ref_mem[48] = 32'h0000_AAAA;
        idle_in();
        gwr_n = 1'b0; adv_n = 1'b0; wdata_i = 32'h0000_BBBB;
        tick();
        idle_in();
        gwr_n = 1'b0; adv_n = 1'b1; wdata_i = 32'h0000_CCCC;
        tick();
        ref_mem[49] = 32'h0000_CCCC;
        rd_check(48, "R12 write burst start");
        rd_check(49, "R12 write suspend");
        rd_check(50, "R12 write untouched");
    endtask

    task automatic t_proc_ignore();
        linear_i = 1'b1;
        idle_in();
        proc_stb_n = 1'b0; addr_i = 6'd40;
        tick();
        idle_in();
        proc_stb_n = 1'b0; ce_pri_n = 1'b1; adv_n = 1'b0; addr_i = 6'd9;
        tick();
        chk("R3 first beat", rdata_o, ref_mem[40]);
        idle_in();
        tick();
        chk("R3 burst continued", rdata_o, ref_mem[41]);
    endtask

    task automatic t_ctrl_desel();
        idle_in();
        ctrl_stb_n = 1'b0; addr_i = 6'd40;
        tick();
        idle_in();
        ctrl_stb_n = 1'b0; ce_pri_n = 1'b1;
        tick();
        chk("R4 previous read shown", 32'(rvalid_o), 32'd1);
        idle_in();
        adv_n = 1'b0;
        tick();
        chk("R4 deselected", 32'(rvalid_o), 32'd0);
        tick();
        chk("R4 stays deselected", 32'(rvalid_o), 32'd0);
    endtask

    task automatic t_enables();
        idle_in();
        ctrl_stb_n = 1'b0; addr_i = 6'd40;
        tick();
        idle_in();
        ctrl_stb_n = 1'b0; ce_hi = 1'b0;
        tick();
        idle_in();
        tick();
        chk("R2 second enable low", 32'(rvalid_o), 32'd0);
        idle_in();
        proc_stb_n = 1'b0; addr_i = 6'd40;
        tick();
        idle_in();
        proc_stb_n = 1'b0; ce_lo_n = 1'b1;
        tick();
        idle_in();
        tick();
        chk("R2 third enable high", 32'(rvalid_o), 32'd0);
        idle_in();
        ctrl_stb_n = 1'b0; ce_hi = 1'b0; gwr_n = 1'b0; addr_i = 6'd5; wdata_i = 32'hDEAD_DEAD;
        tick();
        rd_check(5, "R2 disabled write dropped");
    endtask

    task automatic t_proc_read();
        idle_in();
        proc_stb_n = 1'b0; gwr_n = 1'b0; wr_n = 1'b0; lane_n = 4'h0;
        addr_i = 6'd6; wdata_i = 32'h0BAD_BEEF;
        tick();
        idle_in();
        tick();
        chk("R5 proc start reads", 32'(rvalid_o), 32'd1);
        chk("R5 proc start data", rdata_o, ref_mem[6]);
        rd_check(6, "R5 array unchanged");
    endtask

    initial begin
        linear_i = 1'b1;
        idle_in();
        t_reset();
        t_global();
        t_bytes();
        t_latency();
        t_oe();
        t_bursts();
        t_wr_burst();
        t_proc_ignore();
        t_ctrl_desel();
        t_enables();
        t_proc_read();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule